// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power mode a small processor system occupies and drives the clock and power enables that follow from it. The processor signals a sleep instruction with a one-cycle request. The target depth is read only at that moment: a backup request bit selects the deepest state, a deep-sleep select bit selects the intermediate state, and with neither set the system takes a light nap in which only the processor clock stops. A write to either bit has no effect until a request arrives.

A single masked set of wake sources ends every low-power state. The sources are real-time clock, GPIO, USB and comparator interrupts, the external reset pin, and a wakeup timer. Leaving the light nap restores the processor clock in the following cycle. Leaving the two deeper states first turns the oscillator back on. The processor and peripheral clocks then wait for a settle interval that software programs, so the oscillator has time to stabilise. A wake that coincides with a sleep request cancels the entry.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode output is 2'b00 (active), and the CPU clock, peripheral clock, oscillator and retention outputs are all 1.
- R2: A sleep request in active mode, with no enabled wake, and with backup_req_i=0 and deep_sel_i=0, gives mode 2'b01 from the next cycle. In that mode the CPU clock enable is 0 and the peripheral clock, oscillator and retention enables are 1.
- R3: A sleep request in active mode, with no enabled wake, and with backup_req_i=0 and deep_sel_i=1, gives mode 2'b10. In that mode the CPU clock, peripheral clock and oscillator enables are 0 and retention is 1.
- R4: A sleep request in active mode, with no enabled wake, and with backup_req_i=1, gives mode 2'b11 whatever the value of deep_sel_i. In that mode only retention is 1.
- R5: If sleep_req_i is not asserted, a change to deep_sel_i or backup_req_i leaves the mode and all enables unchanged.
- R6: An enabled wake in mode 2'b01 gives mode 2'b00, with all enables at 1, in the next cycle.
- R7: The bits of wake_src_i are: bit0 real-time clock, bit1 GPIO, bit2 USB, bit3 comparator, bit4 external reset pin, bit5 wakeup timer. A source counts as a wake only while the wake_mask_i bit at the same position is 1. Masked sources have no effect.
- R8: A sleep request in active mode in the same cycle as an enabled wake leaves the block in mode 2'b00 with all enables at 1.
- R9: Take an enabled wake in mode 2'b10 or 2'b11, with settle_cyc_i equal to N at that edge. For the next N cycles the oscillator enable is 1, the CPU and peripheral clock enables are 0, and the mode output keeps the low-power code. After those cycles the mode is 2'b00 and all enables are 1.
- R10: A settle_cyc_i value below 4 acts as 4.
- R11: A sleep request in any state other than active mode has no effect. A wake during the settle interval has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_req_i | input | 1 | One-cycle pulse from a wait-for-interrupt or wait-for-event instruction |
| deep_sel_i | input | 1 | Deep-sleep select, sampled with the sleep request |
| backup_req_i | input | 1 | Backup request, sampled with the sleep request; takes priority over deep_sel_i |
| wake_src_i | input | 6 | Wake sources: rtc, gpio, usb, comparator, reset pin, timer (bit0 to bit5) |
| wake_mask_i | input | 6 | Per-source wake enable |
| settle_cyc_i | input | 8 | Oscillator settle interval in cycles (4 to 255) |
| mode_o | output | 2 | Mode: 00 active, 01 sleep, 10 deep sleep, 11 backup |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | High-speed oscillator enable |
| retain_o | output | 1 | Always-on domain and RAM retention indicator |

## Verification
Mode changes caused by sleep requests, sleep-mode wakes and cancellations are due one clock edge after the inputs are sampled. A wake from a deeper state turns on the oscillator one edge later and turns on the clocks exactly N edges after that. The bench drives inputs on the falling edge. A cycle model built from the requirements advances on the next rising edge, and all outputs are compared with the model at the falling edge that follows. As a result, every result is checked in the exact cycle it is due, and also in every cycle before and after that.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_NAP  = 3'd1,
    ST_DEEP = 3'd2,
    ST_BKUP = 3'd3,
    ST_WARM = 3'd4
  } pm_state_e;

  localparam logic [1:0] MODE_ACT  = 2'b00;
  localparam logic [1:0] MODE_NAP  = 2'b01;
  localparam logic [1:0] MODE_DEEP = 2'b10;
  localparam logic [1:0] MODE_BKUP = 2'b11;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic ret;
  } pm_en_t;

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwr_wake_merge.sv
module pwr_wake_merge #(
  parameter int NUM_WAKE = 6
) (
  input  logic [NUM_WAKE-1:0] src_i,
  input  logic [NUM_WAKE-1:0] mask_i,
  output logic                wake_o
);

  logic [NUM_WAKE-1:0] gated;

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_gate
    assign gated[g] = src_i[g] & mask_i[g];
  end

  assign wake_o = |gated;

endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int CNT_W   = 8,
  parameter int MIN_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] MinVal = CNT_W'(MIN_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d, eff_len;
  logic             cnt_en;

  always_comb begin
    eff_len = (settle_i < MinVal) ? MinVal : settle_i;
    cnt_en  = load_i | (run_i & (cnt_q != '0));
    cnt_d   = cnt_q;
    if (load_i)      cnt_d = eff_len - CNT_W'(1);
    else if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       deep_sel_i,
  input  logic       backup_req_i,
  input  logic       wake_i,
  input  logic       settle_done_i,
  output logic       settle_load_o,
  output logic       settle_run_o,
  output logic [1:0] mode_o,
  output pm_en_t     en_o
);

  pm_state_e  st_q, st_d;
  logic [1:0] from_q, from_d;
  logic       from_en;

  always_comb begin
    st_d          = st_q;
    from_d        = from_q;
    from_en       = 1'b0;
    settle_load_o = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (sleep_req_i && !wake_i) begin
          if (backup_req_i)    st_d = ST_BKUP;
          else if (deep_sel_i) st_d = ST_DEEP;
          else                 st_d = ST_NAP;
        end
      end
      ST_NAP: begin
        if (wake_i) st_d = ST_RUN;
      end
      ST_DEEP, ST_BKUP: begin
        if (wake_i) begin
          st_d          = ST_WARM;
          from_en       = 1'b1;
          from_d        = (st_q == ST_BKUP) ? MODE_BKUP : MODE_DEEP;
          settle_load_o = 1'b1;
        end
      end
      ST_WARM: begin
        if (settle_done_i) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      from_q <= MODE_ACT;
    else if (from_en) from_q <= from_d;
  end

  assign settle_run_o = (st_q == ST_WARM);

  always_comb begin
    mode_o = MODE_ACT;
    en_o   = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, ret: 1'b1};
    unique case (st_q)
      ST_NAP: begin
        mode_o = MODE_NAP;
        en_o   = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, ret: 1'b1};
      end
      ST_DEEP: begin
        mode_o = MODE_DEEP;
        en_o   = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, ret: 1'b1};
      end
      ST_BKUP: begin
        mode_o = MODE_BKUP;
        en_o   = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, ret: 1'b1};
      end
      ST_WARM: begin
        mode_o = from_q;
        en_o   = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, ret: 1'b1};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int NUM_WAKE    = 6,
  parameter int SETTLE_W    = 8,
  parameter int SETTLE_MIN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic                deep_sel_i,
  input  logic                backup_req_i,
  input  logic [NUM_WAKE-1:0] wake_src_i,
  input  logic [NUM_WAKE-1:0] wake_mask_i,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  output logic [1:0]          mode_o,
  output logic                cpu_clk_en_o,
  output logic                per_clk_en_o,
  output logic                osc_en_o,
  output logic                retain_o
);

  logic   rst_n_sync;
  logic   wake_any;
  logic   settle_load, settle_run, settle_done;
  pm_en_t en;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_sync)
  );

  pwr_wake_merge #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .src_i (wake_src_i),
    .mask_i(wake_mask_i),
    .wake_o(wake_any)
  );

  pwr_settle_cnt #(.CNT_W(SETTLE_W), .MIN_CYC(SETTLE_MIN)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .load_i  (settle_load),
    .run_i   (settle_run),
    .settle_i(settle_cyc_i),
    .done_o  (settle_done)
  );

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_sync),
    .sleep_req_i  (sleep_req_i),
    .deep_sel_i   (deep_sel_i),
    .backup_req_i (backup_req_i),
    .wake_i       (wake_any),
    .settle_done_i(settle_done),
    .settle_load_o(settle_load),
    .settle_run_o (settle_run),
    .mode_o       (mode_o),
    .en_o         (en)
  );

  assign cpu_clk_en_o = en.cpu;
  assign per_clk_en_o = en.per;
  assign osc_en_o     = en.osc;
  assign retain_o     = en.ret;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int NUM_WAKE = 6
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic                sleep_req_i,
  input logic                deep_sel_i,
  input logic                backup_req_i,
  input logic [NUM_WAKE-1:0] wake_src_i,
  input logic [NUM_WAKE-1:0] wake_mask_i,
  input logic [1:0]          mode_o,
  input logic                cpu_clk_en_o,
  input logic                per_clk_en_o,
  input logic                osc_en_o
);

  logic woke;
  logic running;
  assign woke    = |(wake_src_i & wake_mask_i);
  assign running = (mode_o == 2'b00) && cpu_clk_en_o;

  // R2: light sleep entry
  p_nap_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    running && sleep_req_i && !woke && !backup_req_i && !deep_sel_i
    |=> mode_o == 2'b01 && !cpu_clk_en_o && per_clk_en_o);

  // R4: backup beats deep select
  p_bkup_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    running && sleep_req_i && !woke && backup_req_i
    |=> mode_o == 2'b11 && !osc_en_o && !per_clk_en_o);

  // R6: one-cycle return from light sleep
  p_nap_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_o == 2'b01 && woke |=> running && per_clk_en_o);

  // R8: coincident wake cancels entry
  p_cancel_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    running && sleep_req_i && woke |=> running);

  // R9: oscillator is running before the CPU clock comes back
  p_osc_first_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(cpu_clk_en_o) |-> $past(osc_en_o));

  // R11: a deep state without a wake holds its mode
  p_deep_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_o[1] && !osc_en_o && !woke |=> $stable(mode_o) && !cpu_clk_en_o);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_sync),
  .sleep_req_i (sleep_req_i),
  .deep_sel_i  (deep_sel_i),
  .backup_req_i(backup_req_i),
  .wake_src_i  (wake_src_i),
  .wake_mask_i (wake_mask_i),
  .mode_o      (mode_o),
  .cpu_clk_en_o(cpu_clk_en_o),
  .per_clk_en_o(per_clk_en_o),
  .osc_en_o    (osc_en_o)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       sleep_req, deep_sel, backup_req;
  logic [5:0] wake_src, wake_mask;
  logic [7:0] settle;
  logic [1:0] mode;
  logic       cpu_en, per_en, osc_en, ret;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state: 0 run, 1 nap, 2 deep, 3 backup, 4 settling
  int       m_st   = 0;
  int       m_cnt  = 0;
  bit [1:0] m_from = 2'b00;

  always #5 clk = ~clk;

  pwr_mode_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .deep_sel_i(deep_sel),
    .backup_req_i(backup_req), .wake_src_i(wake_src), .wake_mask_i(wake_mask),
    .settle_cyc_i(settle), .mode_o(mode), .cpu_clk_en_o(cpu_en),
    .per_clk_en_o(per_en), .osc_en_o(osc_en), .retain_o(ret)
  );

  function automatic bit [5:0] exp_out(input int st, input bit [1:0] from);
    // {mode[1:0], cpu, per, osc, ret}
    case (st)
      0:       return {2'b00, 4'b1111};
      1:       return {2'b01, 4'b0111};
      2:       return {2'b10, 4'b0001};
      3:       return {2'b11, 4'b0001};
      default: return {from, 4'b0011};
    endcase
  endfunction

  task automatic compare(input string tag);
    bit [5:0] exp_v, act_v;
    exp_v = exp_out(m_st, m_from);
    act_v = {mode, cpu_en, per_en, osc_en, ret};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: {mode,cpu,per,osc,ret} actual=%b expected=%b at %0t",
               tag, act_v, exp_v, $time);
    end
  endtask

  task automatic model_step();
    bit w;
    w = |(wake_src & wake_mask);
    case (m_st)
      0: if (sleep_req && !w) m_st = backup_req ? 3 : (deep_sel ? 2 : 1);
      1: if (w) m_st = 0;
      2, 3: if (w) begin
        m_from = (m_st == 3) ? 2'b11 : 2'b10;
        m_cnt  = ((settle < 8'd4) ? 4 : int'(settle)) - 1;
        m_st   = 4;
      end
      default: if (m_cnt == 0) m_st = 0; else m_cnt--;
    endcase
  endtask

  task automatic cyc(input bit sr, input bit ds, input bit br, input bit [5:0] src,
                     input bit [5:0] msk, input bit [7:0] st, input string tag);
    sleep_req = sr; deep_sel = ds; backup_req = br;
    wake_src = src; wake_mask = msk; settle = st;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input bit [7:0] st, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 6'h00, 6'h3f, st, tag);
  endtask

  initial begin
    int rd;
    rst_ni = 1'b0; sleep_req = 0; deep_sel = 0; backup_req = 0;
    wake_src = '0; wake_mask = '0; settle = 8'd4;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 reset");

    // R5: selects without a request
    cyc(0, 1, 0, 6'h00, 6'h3f, 8'd4, "R5 deep_sel alone");
    cyc(0, 0, 1, 6'h00, 6'h3f, 8'd4, "R5 backup_req alone");
    // R2 / R6: light sleep and wake via the timer bit
    cyc(1, 0, 0, 6'h00, 6'h3f, 8'd4, "R2 nap entry");
    idle(2, 8'd4, "R2 nap hold");
    cyc(1, 1, 1, 6'h00, 6'h3f, 8'd4, "R11 request while napping");
    cyc(0, 0, 0, 6'h20, 6'h3f, 8'd4, "R6 nap wake");
    // R7: masked source does nothing; enabled one wakes
    cyc(1, 0, 0, 6'h00, 6'h3f, 8'd4, "R2 nap entry again");
    cyc(0, 0, 0, 6'h04, 6'h3b, 8'd4, "R7 masked usb ignored");
    cyc(0, 0, 0, 6'h3e, 6'h01, 8'd4, "R7 masked others ignored");
    cyc(0, 0, 0, 6'h01, 6'h01, 8'd4, "R7 rtc wakes");
    // R3 / R9: deep sleep, settle of 10
    cyc(1, 1, 0, 6'h00, 6'h3f, 8'd10, "R3 deep entry");
    idle(3, 8'd10, "R3 deep hold");
    cyc(0, 0, 0, 6'h10, 6'h10, 8'd10, "R9 reset pin wake");
    cyc(1, 0, 0, 6'h02, 6'h3f, 8'd10, "R11 request and wake while settling");
    idle(10, 8'd10, "R9 settle window");
    // R4 / R10: backup with settle below minimum
    cyc(1, 1, 1, 6'h00, 6'h3f, 8'd1, "R4 backup priority");
    idle(2, 8'd1, "R4 backup hold");
    cyc(0, 0, 0, 6'h08, 6'h08, 8'd0, "R10 comparator wake, settle 0");
    idle(6, 8'd0, "R10 minimum settle");
    // R8: coincident wake cancels
    cyc(1, 1, 0, 6'h02, 6'h02, 8'd4, "R8 cancel deep");
    cyc(1, 0, 1, 6'h20, 6'h20, 8'd4, "R8 cancel backup");
    cyc(1, 0, 0, 6'h02, 6'h00, 8'd4, "R8 masked wake does not cancel");
    cyc(0, 0, 0, 6'h02, 6'h02, 8'd4, "R6 wake after masked case");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      bit [5:0] src;
      rd  = $urandom(32'd0) % 8;
      src = (rd == 0) ? 6'($urandom) : 6'h00;
      cyc(($urandom % 4) == 0, 1'($urandom), (($urandom % 3) == 0), src,
          6'($urandom) | 6'h21, 8'($urandom % 24), "R9 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule